// File: doc/BRIEF.md
# Serialized Interrupt Frame Encoder

This block reports the levels of a group of interrupt request lines to a host interrupt controller over a single shared line. The line is open-drain in style and clocked by the bus clock. The encoder drives the line only while its output enable is high, and it reads the resolved line level back on a separate input. Each frame has three parts: a start pulse, then one three-clock indication slot per interrupt, then a stop pulse that the host drives. The stop pulse also sets how the next frame begins.

Sixteen legacy IRQ levels always travel in the frame. Four PCI-style interrupts follow them in the frame unless the parallel-mode input is set. In parallel mode those four leave the frame and appear instead on active-low parallel pins. A tie control folds the second PCI interrupt into the first, both in the frame and on the pins.

Start modes work as follows. In continuous mode the encoder starts every frame by itself. In quiet mode it stays silent until an input level changes or the host pulls the line low.

Top module: `sirq_frame_enc`

## Requirements
- R1: While the synchronous active-low reset is applied, `ser_oe` is 0 and `pci_int_n` is all ones. After release, the encoder is in continuous mode.
- R2: In continuous mode the encoder starts each frame by itself. It drives the line low (`ser_oe`=1, `ser_out`=0) for 4 consecutive clocks, and the sample clock of slot 0 follows directly.
- R3: Each slot lasts 3 clocks: sample, recovery, turnaround. In the sample clock, a deasserted interrupt drives the line low and an asserted one leaves it released. In the recovery clock, a slot that drove low drives high. The turnaround clock is released.
- R4: Slot order is IRQ bit 0 to bit 15, then PCI bits 0 to 3 (`pci_int_in[0]` is INTA). A line read high in the sample clock means asserted.
- R5: When `pci_par_mode`=1 the frame has 16 slots, and `pci_int_n` shows the inverted PCI levels one clock after the inputs. When `pci_par_mode`=0 the frame has 20 slots and `pci_int_n` is all ones.
- R6: With `tie_ab`=1, INTA carries INTA OR INTB and INTB reads deasserted. This applies in the frame and on `pci_int_n`.
- R7: All inputs are sampled once, in the clock a frame begins. A change during the frame shows only in the next frame.
- R8: After the last slot the encoder releases the line. It then waits for the host's low pulse. When the line returns high, a pulse of exactly 2 low clocks selects quiet mode and 3 or more selects continuous mode.
- R9: In quiet mode the line stays released while the inputs match the last sampled values. When any IRQ or PCI input level differs, the encoder begins a frame with one driven-low clock, followed directly by the slot 0 sample clock.
- R10: In quiet mode, a host low pulse on the idle line starts a frame. The slot 0 sample clock is the clock after the first clock in which the line reads high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Legacy IRQ levels, 1 = asserted |
| pci_int_in | input | 4 | PCI interrupt levels, bit 0 = INTA, 1 = asserted |
| pci_par_mode | input | 1 | 1 = PCI interrupts on parallel pins, IRQs only in frame |
| tie_ab | input | 1 | 1 = merge INTB into INTA |
| ser_in | input | 1 | Resolved level of the shared line |
| ser_out | output | 1 | Level driven when enabled |
| ser_oe | output | 1 | Drive enable for the shared line |
| pci_int_n | output | 4 | Active-low parallel PCI interrupt pins |

## Verification
The bench goes after four corner cases.

- Stop-pulse length: a 2-clock pulse must switch to quiet mode and a 3-clock pulse back to continuous. An encoder that counted the pulse off by one would keep starting frames in quiet mode, or would never leave it.
- Input change inside a frame: a design that did not sample once would show mixed old and new slots.
- Tie merge in both serial and parallel paths: a missed merge would leave INTB visible.
- Shortened frame in parallel mode: a wrong slot count would leave the line driven into the stop pulse, which the bench flags.

The host-started frame checks that slot 0 starts exactly one clock after the line rises.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_HSTART = 3'd2,
    ST_SLOT   = 3'd3,
    ST_STOP   = 3'd4
  } enc_state_e;

  typedef enum logic {
    MODE_CONT  = 1'b0,
    MODE_QUIET = 1'b1
  } line_mode_e;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } slot_phase_e;
endpackage

// File: rtl/sirq_tie_merge.sv
module sirq_tie_merge #(
  parameter int NUM_PCI = 4
) (
  input  logic [NUM_PCI-1:0] raw,
  input  logic               tie,
  output logic [NUM_PCI-1:0] eff
);
  function automatic logic merged_a(input logic a, input logic b, input logic t);
    return a | (t & b);
  endfunction

  assign eff[0] = merged_a(raw[0], raw[1], tie);
  assign eff[1] = raw[1] & ~tie;

  for (genvar i = 2; i < NUM_PCI; i++) begin : g_pass
    assign eff[i] = raw[i];
  end
endmodule

// File: rtl/sirq_snapshot.sv
module sirq_snapshot #(
  parameter int NUM_IRQ = 16,
  parameter int NUM_PCI = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  logic [NUM_IRQ-1:0]         irq_in,
  input  logic [NUM_PCI-1:0]         pci_raw,
  input  logic [NUM_PCI-1:0]         pci_eff,
  input  logic                       par_mode,
  output logic [NUM_IRQ+NUM_PCI-1:0] slot_vec,
  output logic                       snap_par,
  output logic                       change_pending
);
  localparam int NTOT = NUM_IRQ + NUM_PCI;

  logic [NTOT-1:0] raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vec <= '0;
      raw_q    <= '0;
      snap_par <= 1'b0;
    end else if (capture) begin
      slot_vec <= {pci_eff, irq_in};
      raw_q    <= {pci_raw, irq_in};
      snap_par <= par_mode;
    end
  end

  assign change_pending = ({pci_raw, irq_in} != raw_q);
endmodule

// File: rtl/sirq_stop_detect.sv
module sirq_stop_detect #(
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic ser_in,
  output logic stop_seen,
  output logic stop_to_quiet
);
  localparam int LCW = $clog2(STOP_CONT + 1);

  logic [LCW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !armed) begin
      low_cnt <= '0;
    end else if (!ser_in) begin
      if (low_cnt != LCW'(STOP_CONT)) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  assign stop_seen     = armed && ser_in && (low_cnt >= LCW'(STOP_QUIET));
  assign stop_to_quiet = (low_cnt < LCW'(STOP_CONT));
endmodule

// File: rtl/sirq_par_out.sv
module sirq_par_out #(
  parameter int NUM_PCI = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_mode,
  input  logic [NUM_PCI-1:0] pci_eff,
  output logic [NUM_PCI-1:0] pci_int_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)        pci_int_n <= '1;
    else if (par_mode) pci_int_n <= ~pci_eff;
    else               pci_int_n <= '1;
  end

  // R5
  par_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_mode |=> (pci_int_n == '1));
endmodule

// File: rtl/sirq_frame_enc.sv
module sirq_frame_enc
  import sirq_pkg::*;
#(
  parameter int NUM_IRQ    = 16,
  parameter int NUM_PCI    = 4,
  parameter int START_CONT = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_PCI-1:0] pci_int_in,
  input  logic               pci_par_mode,
  input  logic               tie_ab,
  input  logic               ser_in,
  output logic               ser_out,
  output logic               ser_oe,
  output logic [NUM_PCI-1:0] pci_int_n
);
  localparam int NTOT = NUM_IRQ + NUM_PCI;
  localparam int SIW  = $clog2(NTOT);
  localparam int SCW  = $clog2(START_CONT + 1);
  localparam logic [SIW-1:0] LAST_ALL = SIW'(NTOT - 1);
  localparam logic [SIW-1:0] LAST_IRQ = SIW'(NUM_IRQ - 1);

  enc_state_e  state_q;
  line_mode_e  mode_q;
  slot_phase_e phase_q;
  logic [SIW-1:0]  slot_idx_q;
  logic [SCW-1:0]  start_cnt_q;
  logic [SCW-1:0]  start_last_q;

  logic [NUM_PCI-1:0] pci_eff;
  logic [NTOT-1:0]    slot_vec;
  logic               snap_par;
  logic               change_pending;
  logic               stop_seen;
  logic               stop_to_quiet;

  // named events for checking
  logic frame_begin;
  logic slot_sample;
  logic in_slots;
  logic last_slot;
  logic cur_bit;

  sirq_tie_merge #(.NUM_PCI(NUM_PCI)) u_tie (
    .raw(pci_int_in), .tie(tie_ab), .eff(pci_eff)
  );

  sirq_snapshot #(.NUM_IRQ(NUM_IRQ), .NUM_PCI(NUM_PCI)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(frame_begin),
    .irq_in(irq_in), .pci_raw(pci_int_in), .pci_eff(pci_eff),
    .par_mode(pci_par_mode), .slot_vec(slot_vec), .snap_par(snap_par),
    .change_pending(change_pending)
  );

  sirq_stop_detect #(.STOP_QUIET(STOP_QUIET), .STOP_CONT(STOP_CONT)) u_stop (
    .clk(clk), .rst_n(rst_n), .armed(state_q == ST_STOP), .ser_in(ser_in),
    .stop_seen(stop_seen), .stop_to_quiet(stop_to_quiet)
  );

  sirq_par_out #(.NUM_PCI(NUM_PCI)) u_par (
    .clk(clk), .rst_n(rst_n), .par_mode(pci_par_mode),
    .pci_eff(pci_eff), .pci_int_n(pci_int_n)
  );

  assign frame_begin = (state_q == ST_IDLE) &&
                       (mode_q == MODE_CONT || !ser_in || change_pending);
  assign in_slots    = (state_q == ST_SLOT);
  assign slot_sample = in_slots && (phase_q == PH_SAMPLE);
  assign last_slot   = (slot_idx_q == (snap_par ? LAST_IRQ : LAST_ALL));
  assign cur_bit     = slot_vec[slot_idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      mode_q       <= MODE_CONT;
      phase_q      <= PH_SAMPLE;
      slot_idx_q   <= '0;
      start_cnt_q  <= '0;
      start_last_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          start_cnt_q <= '0;
          if (mode_q == MODE_CONT) begin
            state_q      <= ST_START;
            start_last_q <= SCW'(START_CONT - 1);
          end else if (!ser_in) begin
            state_q <= ST_HSTART;
          end else if (change_pending) begin
            state_q      <= ST_START;
            start_last_q <= '0;
          end
        end
        ST_START: begin
          start_cnt_q <= start_cnt_q + 1'b1;
          if (start_cnt_q == start_last_q) begin
            state_q    <= ST_SLOT;
            slot_idx_q <= '0;
            phase_q    <= PH_SAMPLE;
          end
        end
        ST_HSTART: begin
          if (ser_in) begin
            state_q    <= ST_SLOT;
            slot_idx_q <= '0;
            phase_q    <= PH_SAMPLE;
          end
        end
        ST_SLOT: begin
          case (phase_q)
            PH_SAMPLE:  phase_q <= PH_RECOVER;
            PH_RECOVER: phase_q <= PH_TURN;
            default: begin
              phase_q <= PH_SAMPLE;
              if (last_slot) state_q <= ST_STOP;
              else           slot_idx_q <= slot_idx_q + 1'b1;
            end
          endcase
        end
        ST_STOP: begin
          if (stop_seen) begin
            state_q <= ST_IDLE;
            mode_q  <= stop_to_quiet ? MODE_QUIET : MODE_CONT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ser_oe  = 1'b0;
    ser_out = 1'b1;
    if (state_q == ST_START) begin
      ser_oe  = 1'b1;
      ser_out = 1'b0;
    end else if (in_slots && phase_q == PH_SAMPLE) begin
      ser_oe  = !cur_bit;
      ser_out = 1'b0;
    end else if (in_slots && phase_q == PH_RECOVER) begin
      ser_oe  = !cur_bit;
      ser_out = 1'b1;
    end
  end

  // R1
  reset_release_chk: assert property (@(posedge clk)
    !rst_n |=> !ser_oe);

  // R2
  cont_start_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_begin && mode_q == MODE_CONT) |=> (ser_oe && !ser_out));

  // R3
  recover_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_sample && ser_oe) |=> (ser_oe && ser_out));

  // R7
  snap_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slots && $past(in_slots)) |-> $stable(slot_vec));

  // R8
  quiet_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && stop_to_quiet) |=> (mode_q == MODE_QUIET));

  // R9
  quiet_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && mode_q == MODE_QUIET && ser_in && !change_pending)
      |=> !ser_oe);
endmodule

// File: tb/sirq_frame_enc_tb.sv
module sirq_frame_enc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [3:0]  pci_int_in = '0;
  logic        pci_par_mode = 1'b0;
  logic        tie_ab = 1'b0;
  logic        host_low = 1'b0;
  logic        host_start_flag = 1'b0;
  logic        ser_out, ser_oe, line;
  logic [3:0]  pci_int_n;

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  bit finished = 0;

  typedef struct {
    int          start_len;
    bit          host;
    int          nslots;
    logic [19:0] bits;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = !((ser_oe && !ser_out) || host_low);

  sirq_frame_enc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pci_int_in(pci_int_in),
    .pci_par_mode(pci_par_mode), .tie_ab(tie_ab), .ser_in(line),
    .ser_out(ser_out), .ser_oe(ser_oe), .pci_int_n(pci_int_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // expected slot contents, written from R4/R5/R6
  function automatic exp_t make_exp(input logic [15:0] irq, input logic [3:0] pci,
                                    input bit par, input bit tie, input int slen,
                                    input bit host, input string tag);
    exp_t e;
    logic [3:0] p;
    p = pci;
    if (tie) begin
      if (pci[1]) p[0] = 1'b1;
      p[1] = 1'b0;
    end
    e.start_len = slen;
    e.host      = host;
    e.nslots    = par ? 16 : 20;
    e.bits      = par ? {4'b0, irq} : {p, irq};
    e.tag       = tag;
    return e;
  endfunction

  task automatic push(input exp_t e);
    q.push_back(e);
  endtask

  task automatic stop_pulse(input int len);
    @(negedge clk) host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic host_start();
    @(negedge clk);
    host_low = 1'b1;
    host_start_flag = 1'b1;
    repeat (2) @(negedge clk);
    host_low = 1'b0;
    host_start_flag = 1'b0;
  endtask

  task automatic wait_done(input int k);
    wait (done_cnt >= k);
  endtask

  // monitor: pops expected frames and compares them with the line
  initial begin
    forever begin
      exp_t e;
      logic [19:0] got;
      bit start_ok, rec_ok;
      wait (q.size() != 0);
      e = q.pop_front();
      got = '0;
      start_ok = 1'b1;
      rec_ok = 1'b1;
      if (e.host) begin
        do @(negedge clk); while (!host_start_flag);
        do @(negedge clk); while (line == 1'b0);
        if (ser_oe) start_ok = 1'b0;
        @(negedge clk);
      end else begin
        do @(negedge clk); while (!(ser_oe && !ser_out));
        for (int i = 1; i < e.start_len; i++) begin
          @(negedge clk);
          if (!(ser_oe && !ser_out)) start_ok = 1'b0;
        end
        @(negedge clk);
      end
      check(start_ok, {e.tag, " start"}, 32'(e.start_len), 32'(e.start_len));
      for (int s = 0; s < e.nslots; s++) begin
        got[s] = line;
        @(negedge clk);
        if (!got[s] && !(ser_oe && ser_out)) rec_ok = 1'b0;
        if (got[s] && ser_oe) rec_ok = 1'b0;
        @(negedge clk);
        if (ser_oe) rec_ok = 1'b0;
        @(negedge clk);
      end
      // R4 slot contents and order
      check(got == e.bits, {e.tag, " R4 slots"}, 32'(got), 32'(e.bits));
      // R3 recovery and turnaround phases
      check(rec_ok, {e.tag, " R3 phases"}, 32'(rec_ok), 32'd1);
      // R8 line released after last slot
      check(!ser_oe, {e.tag, " R8 release"}, 32'(ser_oe), 32'd0);
      done_cnt++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    bit quiet_ok;
    irq_in = 16'hA5C3;
    pci_int_in = 4'b0101;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!ser_oe, "R1 oe in reset", 32'(ser_oe), 32'd0);
    check(pci_int_n == 4'hF, "R1 pins in reset", 32'(pci_int_n), 32'hF);
    // F1: continuous start after reset (R1, R2)
    push(make_exp(16'hA5C3, 4'b0101, 0, 0, 4, 0, "F1 R2"));
    rst_n = 1'b1;
    wait_done(1);
    check(pci_int_n == 4'hF, "R5 pins idle serial", 32'(pci_int_n), 32'hF);

    // F2: tie merge in frame, mid-frame change (R6, R7)
    irq_in = 16'h0001;
    pci_int_in = 4'b0011;
    tie_ab = 1'b1;
    push(make_exp(16'h0001, 4'b0011, 0, 1, 4, 0, "F2 R6 R7"));
    stop_pulse(3);
    repeat (12) @(negedge clk);
    irq_in = 16'hFFFF;
    wait_done(2);

    // F3: parallel mode, 16 slots (R5)
    pci_int_in = 4'b1010;
    pci_par_mode = 1'b1;
    tie_ab = 1'b0;
    push(make_exp(16'hFFFF, 4'b1010, 1, 0, 4, 0, "F3 R5"));
    stop_pulse(3);
    wait_done(3);
    check(pci_int_n == 4'b0101, "R5 parallel pins", 32'(pci_int_n), 32'h5);

    // switch to quiet; no change means no frame (R8, R9)
    stop_pulse(2);
    quiet_ok = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (ser_oe) quiet_ok = 1'b0;
    end
    check(quiet_ok, "R9 quiet silent", 32'(quiet_ok), 32'd1);

    // F4: host-started frame (R10)
    push(make_exp(16'hFFFF, 4'b1010, 1, 0, 0, 1, "F4 R10"));
    host_start();
    wait_done(4);

    // F5: change-started frame in quiet mode, tie on pins (R9, R6)
    irq_in = 16'h1234;
    pci_int_in = 4'b0010;
    tie_ab = 1'b1;
    repeat (2) @(negedge clk);
    check(pci_int_n == 4'b1110, "R6 pins tied", 32'(pci_int_n), 32'hE);
    push(make_exp(16'h1234, 4'b0010, 1, 1, 1, 0, "F5 R9"));
    stop_pulse(2);
    wait_done(5);

    // F6: back to continuous, full frame with tie (R8, R6)
    irq_in = 16'h8000;
    pci_int_in = 4'b1110;
    pci_par_mode = 1'b0;
    push(make_exp(16'h8000, 4'b1110, 0, 1, 4, 0, "F6 R8"));
    stop_pulse(3);
    wait_done(6);
    stop_pulse(3);
    repeat (4) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end
endmodule